// File: doc/BRIEF.md
# Element-Addressable Overlapping Register File

This block holds 128 registers of 64 bits each and treats them as one flat, byte-addressable, little-endian store. An access names a base register, an element width (8, 16, 32 or 64 bits) and an element index. The byte position of the element is the base register's first byte plus the index times the element size in bytes. An index past the end of the base register therefore spills into the registers that follow. Byte order inside the store is always little-endian. No memory-side endianness setting affects it.

There is one element read port and one element write port. A second port reads and writes whole 64-bit registers, so scalar views and element views of the same storage can be compared. Element reads are combinational and zero-extend the element to 64 bits. Writes take effect at the clock edge and change only the bytes of the addressed element. An access whose byte position falls beyond the last register is flagged as an error, and an erroneous write changes nothing.

Top module: `elem_regfile`

## Requirements
- R1: After reset every register reads as zero on the full-register port.
- R2: The element byte position is base*8 + index*size, where the width code 0/1/2/3 selects a size of 1/2/4/8 bytes. Halfword index 4 from register 2 is the low halfword of register 3.
- R3: Element 0 occupies the least significant bytes of the base register, and within an element the low byte sits at the lower byte position. Writing 8 to halfword 1 of register 2 gives 0x0000_0000_0008_0000 on the full-register port.
- R4: An element write changes only the bytes of that element. Data bits of wr_data above the element size are ignored.
- R5: An element read returns the element in its low bits, with zeros above the element size.
- R6: When the byte position is 1024 or more, the error output of that port is high. An erroneous write changes no register, and an erroneous read returns zero.
- R7: Element reads are combinational. A read of an element in the cycle after it was written returns the new value.
- R8: The full-register port reads and writes all 64 bits of one register. A 64-bit element read matches the full-register read of the register it lands in.
- R9: When a full-register write and an element write hit the same register in one cycle, the element's bytes take the element data and the other bytes take the full-register data.
- R10: Seven 16-bit elements written from register 0 fill register 0 and the low six bytes of register 1, and leave the top two bytes of register 1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_base | input | 7 | Element read base register |
| rd_width | input | 2 | Element read width code (0=8, 1=16, 2=32, 3=64 bits) |
| rd_index | input | 10 | Element read index |
| rd_data | output | 64 | Element read data, zero-extended |
| rd_err | output | 1 | Element read position out of range |
| wr_en | input | 1 | Element write enable |
| wr_base | input | 7 | Element write base register |
| wr_width | input | 2 | Element write width code |
| wr_index | input | 10 | Element write index |
| wr_data | input | 64 | Element write data, in the low bits |
| wr_err | output | 1 | Element write position out of range |
| full_rd_reg | input | 7 | Full-register read select |
| full_rd_data | output | 64 | Full-register read data |
| full_wr_en | input | 1 | Full-register write enable |
| full_wr_reg | input | 7 | Full-register write select |
| full_wr_data | input | 64 | Full-register write data |

## Verification
The assertions check three things on every cycle. After each accepted element write, the addressed bytes hold the new data and the other bytes of that register are unchanged. An out-of-range write enables no byte. A read never shows bits above the element size, and an erroneous read returns zero. Only the bench's scenarios show that the address arithmetic is correct. These cover the spill into the next register, the little-endian placement seen through the full-register port, the run of seven halfwords, the boundary between the last valid and the first invalid position, and the merge of a full-register write with an element write in the same cycle.

// File: rtl/erf_pkg.sv
package erf_pkg;
    localparam int REG_W     = 64;
    localparam int REG_BYTES = REG_W / 8;
    localparam int LANE_W    = $clog2(REG_BYTES);

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } ew_e;

    function automatic logic [REG_W-1:0] size_mask(ew_e w);
        case (w)
            EW_8:    size_mask = REG_W'(64'h0000_0000_0000_00FF);
            EW_16:   size_mask = REG_W'(64'h0000_0000_0000_FFFF);
            EW_32:   size_mask = REG_W'(64'h0000_0000_FFFF_FFFF);
            default: size_mask = {REG_W{1'b1}};
        endcase
    endfunction
endpackage

// File: rtl/erf_addr.sv
module erf_addr
    import erf_pkg::*;
#(
    parameter int NUM_REGS = 128,
    parameter int IDX_W    = 10,
    localparam int REG_AW  = $clog2(NUM_REGS)
) (
    input  logic [REG_AW-1:0] base,
    input  ew_e               width,
    input  logic [IDX_W-1:0]  index,
    output logic [REG_AW-1:0] reg_idx,
    output logic [LANE_W-1:0] lane,
    output logic              err
);
    localparam int OFF_W = REG_AW + IDX_W + LANE_W + 2;
    localparam logic [OFF_W-1:0] LIMIT = OFF_W'(NUM_REGS * REG_BYTES);

    logic [OFF_W-1:0] off_d;

    always_comb begin
        off_d   = (OFF_W'(base) << LANE_W) + (OFF_W'(index) << width);
        err     = (off_d >= LIMIT);
        lane    = off_d[LANE_W-1:0];
        reg_idx = err ? '0 : off_d[LANE_W +: REG_AW];
    end
endmodule

// File: rtl/erf_rlane.sv
module erf_rlane
    import erf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  word,
    input  ew_e               width,
    input  logic [LANE_W-1:0] lane,
    input  logic              err,
    output logic [REG_W-1:0]  data
);
    logic [REG_W-1:0] shifted_d;

    always_comb begin
        shifted_d = word >> {lane, 3'b000};
        data      = err ? '0 : (shifted_d & size_mask(width));
    end

    AST_RD_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (data & ~size_mask(width)) == '0); // R5
    AST_RD_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (data == '0)); // R6
endmodule

// File: rtl/erf_wlane.sv
module erf_wlane
    import erf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 err,
    input  ew_e                  width,
    input  logic [LANE_W-1:0]    lane,
    input  logic [REG_W-1:0]     data,
    output logic [REG_BYTES-1:0] be,
    output logic [REG_W-1:0]     bits,
    output logic [REG_W-1:0]     data_sh
);
    logic [REG_BYTES-1:0] be_raw_d;

    always_comb begin
        be_raw_d = REG_BYTES'((1 << (1 << width)) - 1) << lane;
        be       = (en && !err) ? be_raw_d : '0;
        for (int i = 0; i < REG_BYTES; i++) begin
            bits[i*8 +: 8] = {8{be[i]}};
        end
        data_sh = (data & size_mask(width)) << {lane, 3'b000};
    end

    AST_ERR_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        (en && err) |-> (be == '0)); // R6
    AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !err) |-> ($countones(be) == (1 << width))); // R4
endmodule

// File: rtl/elem_regfile.sv
module elem_regfile
    import erf_pkg::*;
#(
    parameter int NUM_REGS = 128,
    parameter int IDX_W    = 10,
    localparam int REG_AW  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] rd_base,
    input  logic [1:0]        rd_width,
    input  logic [IDX_W-1:0]  rd_index,
    output logic [REG_W-1:0]  rd_data,
    output logic              rd_err,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_base,
    input  logic [1:0]        wr_width,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [REG_W-1:0]  wr_data,
    output logic              wr_err,
    input  logic [REG_AW-1:0] full_rd_reg,
    output logic [REG_W-1:0]  full_rd_data,
    input  logic              full_wr_en,
    input  logic [REG_AW-1:0] full_wr_reg,
    input  logic [REG_W-1:0]  full_wr_data
);
    logic [REG_W-1:0]     regs_q [NUM_REGS];
    logic [REG_W-1:0]     regs_d [NUM_REGS];

    logic [REG_AW-1:0]    r_reg, w_reg;
    logic [LANE_W-1:0]    r_lane, w_lane;
    logic [REG_BYTES-1:0] w_be;
    logic [REG_W-1:0]     w_bits, w_sh;

    erf_addr #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_rd_addr (
        .base(rd_base), .width(ew_e'(rd_width)), .index(rd_index),
        .reg_idx(r_reg), .lane(r_lane), .err(rd_err)
    );

    erf_addr #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_wr_addr (
        .base(wr_base), .width(ew_e'(wr_width)), .index(wr_index),
        .reg_idx(w_reg), .lane(w_lane), .err(wr_err)
    );

    erf_rlane i_rlane (
        .clk(clk), .rst_n(rst_n), .word(regs_q[r_reg]),
        .width(ew_e'(rd_width)), .lane(r_lane), .err(rd_err), .data(rd_data)
    );

    erf_wlane i_wlane (
        .clk(clk), .rst_n(rst_n), .en(wr_en), .err(wr_err),
        .width(ew_e'(wr_width)), .lane(w_lane), .data(wr_data),
        .be(w_be), .bits(w_bits), .data_sh(w_sh)
    );

    always_comb begin
        regs_d = regs_q;
        if (full_wr_en && (int'(full_wr_reg) < NUM_REGS)) begin
            regs_d[full_wr_reg] = full_wr_data;
        end
        if (w_be != '0) begin
            regs_d[w_reg] = (regs_d[w_reg] & ~w_bits) | (w_sh & w_bits);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign full_rd_data = regs_q[full_rd_reg];

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_err) |=>
        ((regs_q[$past(w_reg)] & $past(w_bits)) == $past(w_sh & w_bits))); // R7
    AST_WR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_err && !full_wr_en) |=>
        ((regs_q[$past(w_reg)] & ~$past(w_bits)) ==
         $past(regs_q[w_reg] & ~w_bits))); // R4
endmodule

// File: tb/test_elem_regfile.sv
module test_elem_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  rd_base = '0;
    logic [1:0]  rd_width = '0;
    logic [9:0]  rd_index = '0;
    logic [63:0] rd_data;
    logic        rd_err;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_base = '0;
    logic [1:0]  wr_width = '0;
    logic [9:0]  wr_index = '0;
    logic [63:0] wr_data = '0;
    logic        wr_err;
    logic [6:0]  full_rd_reg = '0;
    logic [63:0] full_rd_data;
    logic        full_wr_en = 1'b0;
    logic [6:0]  full_wr_reg = '0;
    logic [63:0] full_wr_data = '0;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    elem_regfile i_elem_regfile (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%016h expected 0x%016h", tag, act, exp);
        end
    endtask

    task automatic el_wr(input int base, input int w, input int idx, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_base = 7'(base); wr_width = 2'(w); wr_index = 10'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic full_wr(input int r, input logic [63:0] d);
        @(negedge clk);
        full_wr_en = 1'b1; full_wr_reg = 7'(r); full_wr_data = d;
        @(negedge clk);
        full_wr_en = 1'b0;
    endtask

    task automatic full_rd(input int r, output logic [63:0] d);
        full_rd_reg = 7'(r);
        #1;
        d = full_rd_data;
    endtask

    task automatic el_rd(input int base, input int w, input int idx, output logic [63:0] d);
        rd_base = 7'(base); rd_width = 2'(w); rd_index = 10'(idx);
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        full_rd(0, v);   chk("R1 r0 after reset", v, 64'h0);
        full_rd(127, v); chk("R1 r127 after reset", v, 64'h0);
    endtask

    task automatic t_spill();
        logic [63:0] v;
        el_wr(2, 1, 1, 64'h8);
        full_rd(2, v); chk("R3 halfword 1 of r2 on full port", v, 64'h0000_0000_0008_0000);
        el_rd(2, 1, 1, v); chk("R7 read back next cycle", v, 64'h8);
        el_wr(2, 1, 4, 64'h200);
        full_rd(3, v); chk("R2 halfword 4 from r2 lands in r3", v, 64'h200);
        full_rd(2, v); chk("R4 r2 untouched by spill write", v, 64'h0000_0000_0008_0000);
    endtask

    task automatic t_le();
        logic [63:0] v;
        el_wr(10, 1, 0, 64'h0a05);
        el_rd(10, 0, 0, v); chk("R3 low byte at lower address", v, 64'h05);
        el_rd(10, 0, 1, v); chk("R3 high byte at next address", v, 64'h0a);
        el_rd(10, 2, 0, v); chk("R5 32-bit read zero-extended", v, 64'h0a05);
    endtask

    task automatic t_partial();
        logic [63:0] v;
        full_wr(20, 64'h1122_3344_5566_7788);
        el_wr(20, 0, 3, 64'hFFFF_FFFF_FFFF_FFAB);
        full_rd(20, v); chk("R4 byte 3 only, upper data ignored", v, 64'h1122_3344_AB66_7788);
        el_rd(20, 2, 1, v); chk("R5 upper word zero-extended", v, 64'h1122_3344);
    endtask

    task automatic t_seven();
        logic [63:0] v;
        full_wr(0, 64'hFFFF_FFFF_FFFF_FFFF);
        full_wr(1, 64'hFFFF_FFFF_FFFF_FFFF);
        for (int i = 0; i < 7; i++) el_wr(0, 1, i, 64'(16'h1000 + i));
        full_rd(0, v); chk("R10 r0 filled", v, 64'h1003_1002_1001_1000);
        full_rd(1, v); chk("R10 r1 top bytes kept", v, 64'hFFFF_1006_1005_1004);
    endtask

    task automatic t_width();
        logic [63:0] v, f;
        el_wr(5, 3, 2, 64'hDEAD_BEEF_0123_4567);
        full_rd(7, f); chk("R8 64-bit element index 2 from r5 in r7", f, 64'hDEAD_BEEF_0123_4567);
        el_rd(5, 3, 2, v); chk("R8 element view equals full view", v, f);
    endtask

    task automatic t_err();
        logic [63:0] v;
        full_wr(127, 64'h7777_7777_7777_7777);
        full_rd(0, v);
        el_rd(127, 0, 7, v); chk("R6 last byte not in error", {63'b0, rd_err}, 64'h0);
        @(negedge clk);
        wr_en = 1'b1; wr_base = 7'd127; wr_width = 2'd3; wr_index = 10'd1; wr_data = 64'h5555;
        #1; chk("R6 wr_err past last register", {63'b0, wr_err}, 64'h1);
        @(negedge clk);
        wr_en = 1'b0;
        full_rd(0, v);   chk("R6 no wrap into r0", v, 64'hFFFF_1003_1002_1001 & 64'h0 | 64'h1003_1002_1001_1000);
        full_rd(127, v); chk("R6 r127 unchanged", v, 64'h7777_7777_7777_7777);
        el_rd(127, 3, 1, v); chk("R6 erroneous read is zero", v, 64'h0);
        chk("R6 rd_err high", {63'b0, rd_err}, 64'h1);
        el_wr(127, 0, 7, 64'h99);
        full_rd(127, v); chk("R6 last valid byte written", v, 64'h9977_7777_7777_7777);
    endtask

    task automatic t_collide();
        logic [63:0] v;
        @(negedge clk);
        full_wr_en = 1'b1; full_wr_reg = 7'd30; full_wr_data = 64'hAAAA_AAAA_AAAA_AAAA;
        wr_en = 1'b1; wr_base = 7'd30; wr_width = 2'd0; wr_index = 10'd0; wr_data = 64'h5C;
        @(negedge clk);
        full_wr_en = 1'b0; wr_en = 1'b0;
        full_rd(30, v); chk("R9 element bytes win over full write", v, 64'hAAAA_AAAA_AAAA_AA5C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_spill();
        t_le();
        t_partial();
        t_seven();
        t_width();
        t_err();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #200000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule